// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a synthesizable behavioural model of a small serial EEPROM. It answers a three-wire bus made of a chip select, a shift clock and a data input, and it drives a data output with a separate output-enable in place of a tri-state pin. Chip select and shift clock are brought through a two-flop synchronizer and oversampled in the system clock domain. Every decision is taken on a rising shift-clock edge detected there. A strap input chooses between 128 words of 8 bits and 64 words of 16 bits over the same 1024-bit array.

A transaction opens on a rising chip select. Zeros before the first 1 are skipped. The first 1 is the start bit, and a 2-bit opcode and the address follow it, MSB first. Reads shift out a dummy 0 and then the word. Programming commands (write, erase, write-all, erase-all) are gated by a write-enable latch, which is clear after reset. An accepted programming command starts a self-timed busy period of `PROG_CYCLES` system clocks. If the host drops chip select and raises it again during that period, the data pin reports busy (0) and then ready (1).

The controller is one state machine. Its states are:
- IDLE: select low.
- START: hunting for the start bit.
- OPC: two opcode bits.
- ADDR: address bits.
- DATA: data bits for WRITE and WRITE-ALL.
- READ: dummy bit and then the word.
- HOLD: command finished, further clocks ignored.
- STATUS: ready/busy shown on the data pin.

Its transitions are:
- Any state goes to IDLE when select drops.
- On a select rise it goes to STATUS if busy, otherwise to START.
- START goes to OPC on a 1. OPC goes to ADDR after two bits.
- ADDR goes to READ, DATA or HOLD after the last address bit, depending on the opcode.
- DATA goes to HOLD after the last data bit.
- READ goes to HOLD after the last word bit.

Top module: `serial_eeprom`

## Requirements
- R1: After reset the data output is not driven, writes are disabled and every array bit reads as 1.
- R2: While chip select is low the output enable is low. Dropping chip select before an instruction is complete leaves the array unchanged and starts no busy period.
- R3: Zeros clocked before the first 1 are ignored. The first 1 is the start bit, followed by a 2-bit opcode and then the address MSB first: 7 bits when `org16_i`=0, 6 bits when `org16_i`=1.
- R4: READ (opcode 10) drives a 0 dummy bit after the last address bit's rising edge. On each following rising edge it drives the next word bit, MSB first (8 or 16 bits). READ works whether writes are enabled or not.
- R5: In 16-bit mode, word a holds byte 2a+1 as its upper half and byte 2a as its lower half, as addressed in 8-bit mode.
- R6: WRITE (opcode 01) stores the data bits that follow the address into the addressed word, with no prior erase.
- R7: ERASE (opcode 11) sets the addressed word to all ones. ERASE-ALL (opcode 00 with the top two address bits 10) sets the whole array to ones.
- R8: WRITE-ALL (opcode 00, top address bits 01) writes the following data word to every location.
- R9: Opcode 00 with top address bits 11 enables programming, and 00 disables it. A programming command received while disabled leaves the array unchanged and starts no busy period.
- R10: After a programming command is accepted, a low-then-high chip select during the busy period makes the output driven at 0 until `PROG_CYCLES` clocks have passed, then 1.
- R11: Bits clocked in while a busy status is being shown are ignored.
- R12: If chip select falls in the same sampled cycle as the final data bit's clock edge, the command is aborted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial shift clock |
| di_i | input | 1 | Serial data in |
| org16_i | input | 1 | 1 selects 64 x 16, 0 selects 128 x 8 |
| do_o | output | 1 | Serial data out |
| do_en_o | output | 1 | Data out is driven (low means high impedance) |

## Verification
Two events can land in the same sampled cycle: the shift-clock edge that completes a WRITE and the fall of chip select. The bench provokes this by dropping select and raising the clock at the same instant on the final data bit. Both inputs pass through the same synchronizer, so the block sees them together, and select must win. The bench judges the outcome at the pins: a fresh select rise must show no busy status, and a read-back must return the old word from the reference memory.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_READ,
        ST_HOLD,
        ST_STATUS
    } eep_state_t;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_WRITE,
        CMD_ERASE,
        CMD_WRALL,
        CMD_ERALL
    } prog_kind_t;

    localparam logic [1:0] OPC_EXT   = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_ERASE = 2'b11;

    localparam logic [1:0] EXT_LOCK  = 2'b00;
    localparam logic [1:0] EXT_WRALL = 2'b01;
    localparam logic [1:0] EXT_ERALL = 2'b10;
    localparam logic [1:0] EXT_UNLCK = 2'b11;

endpackage

// File: rtl/eep_pin_sync.sv
module eep_pin_sync #(
    parameter int W = 3
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] pins_i,
    output logic [W-1:0] pins_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= pins_i;
            stage2_q <= stage1_q;
        end
    end

    assign pins_o = stage2_q;
endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
    parameter int CYCLES = 2000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic busy_o
);
    localparam int TW = $clog2(CYCLES + 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= TW'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy_o = (cnt_q != '0);

    // R10
    busy_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> busy_o);

    // R10
    busy_ends_at_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> ($past(cnt_q) == TW'(1)));
endmodule

// File: rtl/eep_store.sv
module eep_store
    import eep_pkg::*;
#(
    parameter int BYTES = 128,
    parameter int AW    = 7
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          org16_i,
    input  logic          prog_go_i,
    input  prog_kind_t    kind_i,
    input  logic [AW-1:0] addr_i,
    input  logic [15:0]   wdata_i,
    output logic [15:0]   rdata_o
);
    logic [BYTES*8-1:0] flat;

    for (genvar b = 0; b < BYTES; b++) begin : g_cell
        localparam logic [AW-1:0] IDX8  = AW'(b);
        localparam logic [AW-2:0] IDX16 = (AW-1)'(b / 2);
        localparam bit            IS_HI = (b % 2) == 1;

        logic [7:0] cell_q;
        logic [7:0] wbyte;
        logic       hit;

        assign hit   = org16_i ? (addr_i[AW-2:0] == IDX16) : (addr_i == IDX8);
        assign wbyte = (org16_i && IS_HI) ? wdata_i[15:8] : wdata_i[7:0];

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                cell_q <= 8'hFF;
            end else if (prog_go_i) begin
                case (kind_i)
                    CMD_WRITE: if (hit) cell_q <= wbyte;
                    CMD_ERASE: if (hit) cell_q <= 8'hFF;
                    CMD_WRALL: cell_q <= wbyte;
                    CMD_ERALL: cell_q <= 8'hFF;
                    default:   ;
                endcase
            end
        end

        assign flat[b*8 +: 8] = cell_q;
    end

    logic [7:0]    rd8;
    logic [7:0]    rd_lo;
    logic [7:0]    rd_hi;
    logic [AW-1:0] lo_idx;
    logic [AW-1:0] hi_idx;

    assign lo_idx = {addr_i[AW-2:0], 1'b0};
    assign hi_idx = {addr_i[AW-2:0], 1'b1};
    assign rd8    = flat[int'(addr_i) * 8 +: 8];
    assign rd_lo  = flat[int'(lo_idx) * 8 +: 8];
    assign rd_hi  = flat[int'(hi_idx) * 8 +: 8];

    assign rdata_o = org16_i ? {rd_hi, rd_lo} : {8'h00, rd8};
endmodule

// File: rtl/serial_eeprom.sv
module serial_eeprom
    import eep_pkg::*;
#(
    parameter int MEM_BITS    = 1024,
    parameter int PROG_CYCLES = 2000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    input  logic org16_i,
    output logic do_o,
    output logic do_en_o
);
    localparam int BYTES = MEM_BITS / 8;
    localparam int AW8   = $clog2(BYTES);
    localparam int AW16  = AW8 - 1;
    localparam int CNT_W = 5;

    // ---------------- input conditioning ----------------
    logic cs_q, sk_q, di_q;
    logic cs_prev_q, sk_prev_q;
    logic cs_rise, sk_rise;

    eep_pin_sync #(.W(3)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pins_i ({cs_i, sk_i, di_i}),
        .pins_o ({cs_q, sk_q, di_q})
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cs_prev_q <= 1'b0;
            sk_prev_q <= 1'b0;
        end else begin
            cs_prev_q <= cs_q;
            sk_prev_q <= sk_q;
        end
    end

    assign cs_rise = cs_q & ~cs_prev_q;
    assign sk_rise = sk_q & ~sk_prev_q;

    // ---------------- datapath registers ----------------
    eep_state_t       state, state_n;
    logic [CNT_W-1:0] bit_cnt;
    logic [1:0]       opc_q;
    logic [AW8-1:0]   addr_sr;
    logic [15:0]      data_sr;
    logic [16:0]      out_sr;
    logic             wr_en_q;
    logic             busy;

    logic [AW8-1:0]   addr_nxt;
    logic [15:0]      data_nxt;
    logic [AW8-1:0]   mem_addr;
    logic [15:0]      rdata;
    logic [1:0]       ext_bits;
    logic [CNT_W-1:0] alen_m1;
    logic [CNT_W-1:0] dlen;
    logic             addr_last;
    logic             data_last;

    logic             prog_go;
    prog_kind_t       prog_kind;
    logic             set_en;
    logic             clr_en;

    assign addr_nxt  = {addr_sr[AW8-2:0], di_q};
    assign data_nxt  = {data_sr[14:0], di_q};
    assign ext_bits  = org16_i ? addr_nxt[AW16-1 -: 2] : addr_nxt[AW8-1 -: 2];
    assign alen_m1   = org16_i ? CNT_W'(AW16 - 1) : CNT_W'(AW8 - 1);
    assign dlen      = org16_i ? CNT_W'(16) : CNT_W'(8);
    assign addr_last = (bit_cnt == alen_m1);
    assign data_last = (bit_cnt == dlen - 1'b1);
    assign mem_addr  = (state == ST_ADDR) ? addr_nxt : addr_sr;

    // ---------------- next-state logic ----------------
    always_comb begin
        state_n   = state;
        prog_go   = 1'b0;
        prog_kind = CMD_NONE;
        set_en    = 1'b0;
        clr_en    = 1'b0;
        if (!cs_q) begin
            state_n = ST_IDLE;
        end else if (cs_rise) begin
            state_n = busy ? ST_STATUS : ST_START;
        end else if (sk_rise) begin
            unique case (state)
                ST_IDLE:   state_n = ST_IDLE;
                ST_START:  if (di_q) state_n = ST_OPC;
                ST_OPC:    if (bit_cnt == CNT_W'(1)) state_n = ST_ADDR;
                ST_ADDR: begin
                    if (addr_last) begin
                        case (opc_q)
                            OPC_READ:  state_n = ST_READ;
                            OPC_WRITE: state_n = ST_DATA;
                            OPC_ERASE: begin
                                state_n   = ST_HOLD;
                                prog_go   = wr_en_q;
                                prog_kind = CMD_ERASE;
                            end
                            default: begin
                                case (ext_bits)
                                    EXT_UNLCK: begin
                                        state_n = ST_HOLD;
                                        set_en  = 1'b1;
                                    end
                                    EXT_LOCK: begin
                                        state_n = ST_HOLD;
                                        clr_en  = 1'b1;
                                    end
                                    EXT_ERALL: begin
                                        state_n   = ST_HOLD;
                                        prog_go   = wr_en_q;
                                        prog_kind = CMD_ERALL;
                                    end
                                    default: state_n = ST_DATA;
                                endcase
                            end
                        endcase
                    end
                end
                ST_DATA: begin
                    if (data_last) begin
                        state_n   = ST_HOLD;
                        prog_go   = wr_en_q;
                        prog_kind = (opc_q == OPC_WRITE) ? CMD_WRITE : CMD_WRALL;
                    end
                end
                ST_READ:   if (bit_cnt == dlen) state_n = ST_HOLD;
                ST_HOLD:   state_n = ST_HOLD;
                ST_STATUS: state_n = ST_STATUS;
            endcase
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // ---------------- shift registers and enable latch ----------------
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bit_cnt <= '0;
            opc_q   <= '0;
            addr_sr <= '0;
            data_sr <= '0;
            out_sr  <= '0;
            wr_en_q <= 1'b0;
        end else begin
            if (set_en) begin
                wr_en_q <= 1'b1;
            end else if (clr_en) begin
                wr_en_q <= 1'b0;
            end
            if (cs_rise) begin
                bit_cnt <= '0;
                opc_q   <= '0;
                addr_sr <= '0;
                data_sr <= '0;
            end else if (cs_q && sk_rise) begin
                case (state)
                    ST_OPC: begin
                        opc_q   <= {opc_q[0], di_q};
                        bit_cnt <= (bit_cnt == CNT_W'(1)) ? '0 : bit_cnt + 1'b1;
                    end
                    ST_ADDR: begin
                        addr_sr <= addr_nxt;
                        if (addr_last) begin
                            bit_cnt <= '0;
                            out_sr  <= org16_i ? {1'b0, rdata} : {1'b0, rdata[7:0], 8'h00};
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        data_sr <= data_nxt;
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    ST_READ: begin
                        out_sr  <= {out_sr[15:0], 1'b0};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        do_en_o = (state == ST_READ) || (state == ST_STATUS);
        if (state == ST_STATUS) begin
            do_o = ~busy;
        end else if (state == ST_READ) begin
            do_o = out_sr[16];
        end else begin
            do_o = 1'b0;
        end
    end

    // ---------------- sub-blocks ----------------
    eep_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (prog_go),
        .busy_o  (busy)
    );

    eep_store #(.BYTES(BYTES), .AW(AW8)) u_store (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .org16_i   (org16_i),
        .prog_go_i (prog_go),
        .kind_i    (prog_kind),
        .addr_i    (mem_addr),
        .wdata_i   (data_nxt),
        .rdata_o   (rdata)
    );

    // ---------------- assertions ----------------
    // R9
    prog_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        prog_go |-> wr_en_q);

    // R11
    prog_not_while_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        prog_go |-> !busy);

    // R2
    hiz_when_deselected_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cs_q |=> !do_en_o);

    // R4
    read_dummy_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(state == ST_READ) |-> (do_en_o && !do_o));
endmodule

// File: tb/serial_eeprom_tb_top.sv
module serial_eeprom_tb_top;
    localparam int HALF = 8;
    localparam int PROG = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b0;
    logic do_w, den_w;
    logic last_dq, last_de;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] ref_mem [0:127];
    bit         ref_en;

    always #4 clk = ~clk;

    serial_eeprom #(.MEM_BITS(1024), .PROG_CYCLES(PROG)) dut_i (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .cs_i    (cs),
        .sk_i    (sk),
        .di_i    (di),
        .org16_i (org),
        .do_o    (do_w),
        .do_en_o (den_w)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sk_bit(input logic b);
        di = b;
        wait_n(HALF);
        sk = 1'b1;
        wait_n(HALF);
        last_dq = do_w;
        last_de = den_w;
        sk = 1'b0;
    endtask

    task automatic cs_hi();
        @(negedge clk);
        cs = 1'b1;
        wait_n(HALF);
    endtask

    task automatic cs_lo();
        cs = 1'b0;
        di = 1'b0;
        wait_n(HALF);
    endtask

    function automatic int alen();
        return org ? 6 : 7;
    endfunction

    function automatic int dlen();
        return org ? 16 : 8;
    endfunction

    function automatic int ref_rd(input int a);
        if (org) return {ref_mem[2*a+1], ref_mem[2*a]};
        return int'(ref_mem[a]);
    endfunction

    task automatic ref_wr(input int a, input int d);
        if (org) begin
            ref_mem[2*a]   = d[7:0];
            ref_mem[2*a+1] = d[15:8];
        end else begin
            ref_mem[a] = d[7:0];
        end
    endtask

    task automatic send_head(input logic [1:0] op, input int a);
        sk_bit(1'b1);
        sk_bit(op[1]);
        sk_bit(op[0]);
        for (int i = alen() - 1; i >= 0; i--) sk_bit(1'((a >> i) & 1));
    endtask

    task automatic send_data(input int d);
        for (int i = dlen() - 1; i >= 0; i--) sk_bit(1'((d >> i) & 1));
    endtask

    task automatic do_read(input int a, input string req);
        int v;
        cs_hi();
        send_head(2'b10, a);
        chk(last_de === 1'b1 && last_dq === 1'b0, "R4 dummy bit", {last_de, last_dq}, 2);
        v = 0;
        for (int i = 0; i < dlen(); i++) begin
            sk_bit(1'b0);
            v = (v << 1) | int'(last_dq);
        end
        cs_lo();
        chk(v == ref_rd(a), req, v, ref_rd(a));
    endtask

    task automatic status_check(input bit expect_busy, input string req);
        cs_hi();
        if (expect_busy) begin
            chk(den_w === 1'b1 && do_w === 1'b0, {req, " busy"}, {den_w, do_w}, 2);
            wait_n(PROG + 20);
            chk(den_w === 1'b1 && do_w === 1'b1, {req, " ready"}, {den_w, do_w}, 3);
        end else begin
            chk(den_w === 1'b0, {req, " no busy"}, den_w, 0);
        end
        cs_lo();
    endtask

    task automatic ext_cmd(input logic [1:0] ext);
        cs_hi();
        send_head(2'b00, int'(ext) << (alen() - 2));
    endtask

    initial begin : main
        for (int i = 0; i < 128; i++) ref_mem[i] = 8'hFF;
        ref_en = 1'b0;
        wait_n(10);
        rst_n = 1'b1;
        wait_n(4);
        // R1 reset state
        chk(den_w === 1'b0, "R1 output idle after reset", den_w, 0);
        do_read(5, "R1 erased after reset");

        // R9 write while disabled
        cs_hi(); send_head(2'b01, 5); send_data(8'h00); cs_lo();
        status_check(1'b0, "R9 disabled write");
        do_read(5, "R9 disabled write unchanged");

        // R3 leading zeros then enable
        cs_hi(); sk_bit(1'b0); sk_bit(1'b0);
        send_head(2'b00, 3 << 5); cs_lo();
        ref_en = 1'b1;

        // R6 write x8, R10 status
        cs_hi(); send_head(2'b01, 5); send_data(8'hA5); cs_lo();
        ref_wr(5, 8'hA5);
        status_check(1'b1, "R10 write");
        do_read(5, "R6 R3 write x8");

        // R5 x16 mapping
        org = 1'b1;
        cs_hi(); send_head(2'b01, 3); send_data(16'h1234); cs_lo();
        ref_wr(3, 16'h1234);
        status_check(1'b1, "R10 write x16");
        do_read(3, "R6 write x16");
        org = 1'b0;
        do_read(6, "R5 low byte");
        do_read(7, "R5 high byte");

        // R7 erase
        cs_hi(); send_head(2'b11, 6); cs_lo();
        ref_mem[6] = 8'hFF;
        status_check(1'b1, "R7 erase");
        org = 1'b1;
        do_read(3, "R7 erase word");
        org = 1'b0;

        // R11 ignored while busy
        cs_hi(); send_head(2'b01, 10); send_data(8'h55); cs_lo();
        ref_wr(10, 8'h55);
        cs_hi();
        chk(den_w === 1'b1 && do_w === 1'b0, "R11 status while busy", {den_w, do_w}, 2);
        send_head(2'b01, 10); send_data(8'hAA); cs_lo();
        wait_n(PROG + 20);
        do_read(10, "R11 busy write ignored");

        // R2 abort
        cs_hi(); send_head(2'b01, 11);
        for (int i = 0; i < 4; i++) sk_bit(1'b0);
        chk(den_w === 1'b0, "R2 output idle mid-write", den_w, 0);
        cs_lo();
        chk(den_w === 1'b0, "R2 output idle with select low", den_w, 0);
        status_check(1'b0, "R2 abort");
        do_read(11, "R2 abort unchanged");

        // R12 select fall with final data edge
        cs_hi(); send_head(2'b01, 12);
        for (int i = 0; i < 7; i++) sk_bit(1'b0);
        di = 1'b1;
        wait_n(HALF);
        cs = 1'b0;
        sk = 1'b1;
        wait_n(HALF);
        sk = 1'b0;
        di = 1'b0;
        chk(den_w === 1'b0, "R12 output idle", den_w, 0);
        status_check(1'b0, "R12 same-cycle abort");
        do_read(12, "R12 same-cycle abort unchanged");

        // R8 write-all
        ext_cmd(2'b01); send_data(8'h3C); cs_lo();
        for (int i = 0; i < 128; i++) ref_mem[i] = 8'h3C;
        status_check(1'b1, "R8 write-all");
        do_read(0, "R8 write-all low");
        do_read(77, "R8 write-all mid");
        do_read(127, "R8 write-all top");

        // R9 disable then erase
        ext_cmd(2'b00); cs_lo();
        ref_en = 1'b0;
        cs_hi(); send_head(2'b11, 0); cs_lo();
        status_check(1'b0, "R9 disabled erase");
        do_read(0, "R9 disabled erase unchanged");
        do_read(127, "R4 read while disabled");

        // R7 erase-all
        ext_cmd(2'b11); cs_lo();
        ref_en = 1'b1;
        ext_cmd(2'b10); cs_lo();
        for (int i = 0; i < 128; i++) ref_mem[i] = 8'hFF;
        status_check(1'b1, "R7 erase-all");
        do_read(64, "R7 erase-all x8");
        org = 1'b1;
        do_read(63, "R7 erase-all x16");

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule